// File: doc/BRIEF.md
# Bus Cycle Type Classifier

This block sits between a 32-bit processor core and its memory system. For every bus slot it takes the core's request (address, transfer size, a transfer flag and a coprocessor flag) and turns it into a two-bit cycle code together with the address and size code that go to memory. The code tells the memory controller whether the slot is a fresh, unrelated access, a continuation of the previous access, an idle slot, or a coprocessor register move.

A continuation (sequential) code is issued when the new address equals the last transferred address or lies a halfword or a word above it, and that address still falls inside the same page. Only slots that really move data to or from memory update the remembered address, so an idle slot or a coprocessor slot can sit between two accesses without breaking the sequential run. The page size is a parameter.

The classified slot can be presented early, one clock after the request (for DRAM-style controllers that need time to set up), or one clock later still, aligned with the data phase (for SRAM or ROM). A single enable input picks the timing.

Top module: `bus_cycle_classifier`

## Requirements
- R1: The cycle code is 2'b00 for nonsequential, 2'b01 for sequential, 2'b10 for internal and 2'b11 for coprocessor transfer.
- R2: A slot with neither the transfer flag nor the coprocessor flag set is coded internal (2'b10); a slot with the coprocessor flag set is coded coprocessor (2'b11), whatever the transfer flag.
- R3: A transfer whose address equals the last transferred address, or is 2 or 4 above it, is coded sequential (2'b01).
- R4: A transfer whose address is in any other relation to the last transferred address (lower, +1, +8, far away) is coded nonsequential (2'b00).
- R5: A transfer that would otherwise be sequential but whose address has all-zero page-offset bits (PAGE_BYTES = 1024, offset bits [9:0]) and differs from the last address is coded nonsequential.
- R6: The first transfer after reset is nonsequential regardless of its address.
- R7: Internal and coprocessor slots do not change the remembered address, so a transfer following them is compared with the last real transfer.
- R8: With pipe_en = 1 the code, address and size of a request appear on the outputs one clock after the edge that samples it; with pipe_en = 0 they appear one clock later (two clocks after sampling).
- R9: The output address and size equal the request address and size (size 2'b00 byte, 2'b01 halfword, 2'b10 word).
- R10: During and right after reset the outputs show an internal cycle with address 0 and size 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pipe_en | input | 1 | 1: early (pipelined) output timing, 0: data-aligned timing |
| req_xfer | input | 1 | Core requests a memory transfer this slot |
| req_copro | input | 1 | Core uses the bus for a coprocessor register move |
| req_size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word |
| req_addr | input | 32 | Requested byte address |
| bus_code | output | 2 | Cycle code to memory |
| bus_size | output | 2 | Size code to memory |
| bus_addr | output | 32 | Address to memory |

## Verification
On every cycle the assertions check that a sequential code never spans a page change, that the first transfer after reset is nonsequential, that idle and coprocessor slots leave the remembered address alone, and that the data-aligned output is the early output delayed by one clock. Whether a particular address step earns a sequential code, how an idle slot between two accesses is handled, and the end-to-end latency in both timing modes are shown only by the bench's request streams and their expected codes, which it replays in both modes and around a reset in the middle of a run.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [1:0] {
    CYC_NSEQ  = 2'b00,
    CYC_SEQ   = 2'b01,
    CYC_IDLE  = 2'b10,
    CYC_COPRO = 2'b11
  } cyc_code_e;

  typedef struct packed {
    cyc_code_e   code;
    logic [1:0]  size;
    logic [31:0] addr;
  } bus_beat_t;

  localparam bus_beat_t BEAT_RESET = '{code: CYC_IDLE, size: 2'b00, addr: 32'h0};

  // Address step relation: same, +halfword or +word.
  function automatic logic step_related(input logic [31:0] now_addr,
                                        input logic [31:0] last_addr);
    logic [31:0] diff;
    diff = now_addr - last_addr;
    return (diff == 32'd0) || (diff == 32'd2) || (diff == 32'd4);
  endfunction

  // True when the address sits on the first byte of a page.
  function automatic logic page_origin(input logic [31:0] now_addr,
                                       input int unsigned offset_bits);
    logic [31:0] mask;
    mask = (32'd1 << offset_bits) - 32'd1;
    return (now_addr & mask) == 32'd0;
  endfunction

  // Page number comparison used by checks.
  function automatic logic same_page(input logic [31:0] a,
                                     input logic [31:0] b,
                                     input int unsigned offset_bits);
    return (a >> offset_bits) == (b >> offset_bits);
  endfunction

endpackage

// File: rtl/bcc_decide.sv
module bcc_decide
  import bcc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              copro,
  input  logic [ADDR_W-1:0] addr,
  output cyc_code_e         code
);

  localparam int unsigned OFFSET_BITS = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] last_addr;
  logic              last_valid;

  // Named internal events
  logic ev_moves_data;
  logic ev_step_ok;
  logic ev_page_cross;
  logic ev_seq;

  assign ev_moves_data = xfer && !copro;
  assign ev_step_ok    = last_valid && step_related(addr, last_addr);
  assign ev_page_cross = (addr != last_addr) && page_origin(addr, OFFSET_BITS);
  assign ev_seq        = ev_moves_data && ev_step_ok && !ev_page_cross;

  always_comb begin
    if (copro)           code = CYC_COPRO;
    else if (!xfer)      code = CYC_IDLE;
    else if (ev_seq)     code = CYC_SEQ;
    else                 code = CYC_NSEQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr  <= '0;
      last_valid <= 1'b0;
    end else if (ev_moves_data) begin
      last_addr  <= addr;
      last_valid <= 1'b1;
    end
  end

  // R5: a sequential code never spans a page change
  assert_seq_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CYC_SEQ) |-> same_page(addr, last_addr, OFFSET_BITS));

  // R6: first transfer after reset is nonsequential
  assert_first_nonseq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!last_valid && xfer && !copro) |-> (code == CYC_NSEQ));

  // R7: idle and coprocessor slots keep the remembered address
  assert_hold_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((code == CYC_IDLE) || (code == CYC_COPRO)) |=> $stable(last_addr));

endmodule

// File: rtl/bcc_stage.sv
module bcc_stage
  import bcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bus_beat_t d,
  output bus_beat_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= BEAT_RESET;
    else        q <= d;
  end

endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
  import bcc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 1024,
  parameter int unsigned STAGES     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pipe_en,
  input  logic        req_xfer,
  input  logic        req_copro,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_addr,
  output logic [1:0]  bus_code,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_addr
);

  cyc_code_e code_now;
  bus_beat_t beat_now;
  bus_beat_t beat_q [STAGES+1];
  bus_beat_t beat_out;

  bcc_decide #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(32)) u_decide (
    .clk   (clk),
    .rst_n (rst_n),
    .xfer  (req_xfer),
    .copro (req_copro),
    .addr  (req_addr),
    .code  (code_now)
  );

  assign beat_now = '{code: code_now, size: req_size, addr: req_addr};
  assign beat_q[0] = beat_now;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    bcc_stage u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (beat_q[g]),
      .q     (beat_q[g+1])
    );
  end

  // Early output taps the first register, data-aligned the last one.
  assign beat_out = pipe_en ? beat_q[1] : beat_q[STAGES];

  assign bus_code = beat_out.code;
  assign bus_size = beat_out.size;
  assign bus_addr = beat_out.addr;

  logic rst_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b0;
    else        rst_seen <= 1'b1;
  end

  // R8: data-aligned output is the early output one clock later
  assert_late_follows_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |-> (beat_q[STAGES] == $past(beat_q[STAGES-1])));

  // R10: reset shows an internal cycle
  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> (bus_code == CYC_IDLE) && (bus_addr == 32'h0));

  // R2: coprocessor flag always yields the coprocessor code
  assert_copro_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_copro |=> (beat_q[1].code == CYC_COPRO));

endmodule

// File: tb/bus_cycle_classifier_test.sv
module bus_cycle_classifier_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_en = 1'b1;
  logic        req_xfer = 1'b0;
  logic        req_copro = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = 32'h0;
  logic [1:0]  bus_code;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  bus_cycle_classifier uut (
    .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en),
    .req_xfer(req_xfer), .req_copro(req_copro),
    .req_size(req_size), .req_addr(req_addr),
    .bus_code(bus_code), .bus_size(bus_size), .bus_addr(bus_addr)
  );

  // {xfer, copro, size, addr, expected code}
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b10, 32'h0000_0100, 2'b00}, // R6 first after reset
    {1'b1, 1'b0, 2'b10, 32'h0000_0104, 2'b01}, // R3 +4
    {1'b1, 1'b0, 2'b01, 32'h0000_0106, 2'b01}, // R3 +2
    {1'b1, 1'b0, 2'b10, 32'h0000_0106, 2'b01}, // R3 same
    {1'b0, 1'b0, 2'b10, 32'h0000_0000, 2'b10}, // R2 idle
    {1'b1, 1'b0, 2'b10, 32'h0000_010A, 2'b01}, // R7 seq after idle
    {1'b1, 1'b1, 2'b10, 32'h0000_0000, 2'b11}, // R2 copro
    {1'b1, 1'b0, 2'b10, 32'h0000_010E, 2'b01}, // R7 seq after copro
    {1'b1, 1'b0, 2'b10, 32'h0000_0200, 2'b00}, // R4 far
    {1'b1, 1'b0, 2'b10, 32'h0000_03FC, 2'b00}, // R4 far
    {1'b1, 1'b0, 2'b10, 32'h0000_0400, 2'b00}, // R5 page cross +4
    {1'b1, 1'b0, 2'b00, 32'h0000_0401, 2'b00}, // R4 +1
    {1'b1, 1'b0, 2'b01, 32'h0000_0403, 2'b01}, // R3 +2
    {1'b1, 1'b0, 2'b00, 32'h0000_07FE, 2'b00}, // R4 far
    {1'b1, 1'b0, 2'b01, 32'h0000_0800, 2'b00}, // R5 page cross +2
    {1'b1, 1'b0, 2'b10, 32'h0000_0800, 2'b01}, // R3 same at page origin
    {1'b1, 1'b0, 2'b10, 32'h0000_07FC, 2'b00}  // R4 backwards
  };

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual code/size/addr %h, expected %h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    req_xfer = 1'b0; req_copro = 1'b0; req_size = 2'b00; req_addr = 32'h0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive_idle();
    @(negedge clk);
    @(negedge clk);
    check("R10 reset", {bus_code, bus_size, bus_addr}, {2'b10, 2'b00, 32'h0});
    rst_n = 1'b1;
  endtask

  task automatic run_table(input int lat);
    for (int i = 0; i < NV + lat; i++) begin
      if (i > 0) @(negedge clk);
      if (i >= lat) begin
        logic [37:0] v;
        v = VEC[i-lat];
        check(lat == 1 ? "R1/R8 table early" : "R1/R8 table aligned",
              {bus_code, bus_size, bus_addr}, {v[1:0], v[35:34], v[33:2]});
      end
      if (i < NV) begin
        req_xfer  = VEC[i][37];
        req_copro = VEC[i][36];
        req_size  = VEC[i][35:34];
        req_addr  = VEC[i][33:2];
      end else drive_idle();
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // Early timing pass
    pipe_en = 1'b1;
    do_reset();
    run_table(1);

    // Data-aligned timing pass
    pipe_en = 1'b0;
    do_reset();
    @(negedge clk);
    check("R10 idle after reset aligned", {bus_code, bus_size, bus_addr}, {2'b10, 2'b00, 32'h0});
    run_table(2);

    // R8: latency difference observed directly
    pipe_en = 1'b1;
    do_reset();
    req_xfer = 1'b1; req_size = 2'b10; req_addr = 32'h0000_1000;
    @(negedge clk);
    drive_idle();
    check("R8 early one clock", {bus_code, bus_size, bus_addr}, {2'b00, 2'b10, 32'h0000_1000});
    pipe_en = 1'b0;
    do_reset();
    req_xfer = 1'b1; req_size = 2'b10; req_addr = 32'h0000_1000;
    @(negedge clk);
    drive_idle();
    check("R8 aligned not yet", {bus_code, bus_size, bus_addr}, {2'b10, 2'b00, 32'h0});
    @(negedge clk);
    check("R8 aligned two clocks", {bus_code, bus_size, bus_addr}, {2'b00, 2'b10, 32'h0000_1000});

    // R6: mid-run reset forgets the last address
    pipe_en = 1'b1;
    do_reset();
    req_xfer = 1'b1; req_size = 2'b10; req_addr = 32'h0000_0020;
    @(negedge clk);
    req_addr = 32'h0000_0024;
    @(negedge clk);
    check("R3 seq before reset", {bus_code, bus_size, bus_addr}, {2'b01, 2'b10, 32'h0000_0024});
    do_reset();
    req_xfer = 1'b1; req_size = 2'b10; req_addr = 32'h0000_0028;
    @(negedge clk);
    drive_idle();
    check("R6 nonseq after reset", {bus_code, bus_size, bus_addr}, {2'b00, 2'b10, 32'h0000_0028});

    // R4: +8 step is not sequential; R9 byte size passes through
    req_xfer = 1'b1; req_size = 2'b00; req_addr = 32'h0000_0030;
    @(negedge clk);
    drive_idle();
    check("R4 plus eight", {bus_code, bus_size, bus_addr}, {2'b00, 2'b00, 32'h0000_0030});

    // R2: copro with xfer low still coded coprocessor
    req_copro = 1'b1; req_xfer = 1'b0; req_size = 2'b01; req_addr = 32'h0000_0034;
    @(negedge clk);
    drive_idle();
    check("R2 copro without xfer", {bus_code, bus_size, bus_addr}, {2'b11, 2'b01, 32'h0000_0034});

    // R7: remembered address still 0x30 after copro slot
    req_xfer = 1'b1; req_size = 2'b10; req_addr = 32'h0000_0034;
    @(negedge clk);
    drive_idle();
    check("R7 compared with last transfer", {bus_code, bus_size, bus_addr}, {2'b01, 2'b10, 32'h0000_0034});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule